// File: doc/BRIEF.md
# Preloadable Timer / Event Counter

This block is a 16-bit up-counter with a reload value. Software reaches it through a byte-wide register port with three registers: a low preload byte, a high preload byte and a control byte. The control byte picks what makes the counter advance and also starts or stops it. In timer mode the counter advances on each cycle in which the internal tick enable is high. In event mode it advances once per rising edge of an external input. That input is first brought into the clock domain by a synchronizer.

The preload is written one byte at a time, low byte first. The low byte waits in a holding buffer. When the high byte is written, both bytes move into the 16-bit preload in a single cycle, so the counter never sees half of a new value. If the counter is stopped at that moment, the count register takes the new preload as well. When the counter is at 0xFFFF, its next count step reloads the preload value instead of wrapping to zero. That same step raises a one-cycle overflow request for an interrupt controller.

A read of the low byte returns the live count and, in the same cycle, captures the high byte of the count. A following read of the high byte therefore returns a value that belongs with the low byte just read.

Top module: `ptmr_top`

## Requirements
- R1: After reset the count, the preload and the control register are all zero, and the overflow request is low.
- R2: A write to address 0 (low byte) only loads a holding buffer. It changes neither the preload nor the count.
- R3: A write to address 1 (high byte) loads the preload with {written byte, buffered low byte} in a single cycle. If the run bit is clear at that time, the count is loaded with the same value.
- R4: Control bits 7:6 = 2'b10 selects timer mode. While control bit 4 (run) is set, the count rises by one on each cycle in which tick_en is high.
- R5: Control bits 7:6 = 2'b01 selects event mode. While run is set, each rising edge of evt_in adds exactly one count after the synchronizer delay, however long the input stays high.
- R6: With the run bit clear, or with mode 2'b00 or 2'b11, the count does not change, whatever tick_en and evt_in do.
- R7: A count step taken while the count is 0xFFFF loads the preload into the count and drives ovf_req high for exactly the following cycle.
- R8: A read of address 0 returns the live low byte of the count and captures its high byte. A read of address 1 returns that captured byte, even if the count has changed since.
- R9: A preload write while the run bit is set leaves the count untouched.
- R10: A read of address 2 returns the control register with bits 7:6 and 4 as written and all other bits zero. A read of address 3, or any cycle without rd_en, returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 control |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational, valid while rd_en is high) |
| tick_en | input | 1 | Internal clock enable used in timer mode |
| evt_in | input | 1 | Asynchronous external event input |
| ovf_req | output | 1 | One-cycle overflow request |

## Verification
The bench builds the block with its default parameters: an 8-bit byte, which gives a 16-bit count, and a two-stage synchronizer. At these sizes a preload near 0xFFFF reaches the reload boundary within a few ticks. A table of preloads and tick counts covers plain counting, a single reload, and the repeated reload that occurs when the preload itself is 0xFFFF, with the number of overflow pulses counted each time. Directed tests then cover the write ordering of the preload, running versus stopped writes, every mode encoding, held event levels and the captured high byte.

// File: rtl/ptmr_pkg.sv
// Package: shared register addresses and mode encoding for the preloadable timer.
// Assumes a two-bit register address and a two-bit mode field in control bits 7:6.
package ptmr_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'b00,
        MODE_EVENT = 2'b01,
        MODE_TIMER = 2'b10,
        MODE_RSVD  = 2'b11
    } ptmr_mode_e;

    localparam logic [1:0] ADDR_LO   = 2'd0;
    localparam logic [1:0] ADDR_HI   = 2'd1;
    localparam logic [1:0] ADDR_CTRL = 2'd2;

    localparam int CTRL_RUN_BIT = 4;
endpackage

// File: rtl/ptmr_edge_sync.sv
// Module: brings an asynchronous input into the clock domain through a chain of
// STAGES flops, then gives a one-cycle pulse for each rising edge.
// Assumes each high and low level of the input lasts longer than one clock period.
module ptmr_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    // Shift the input through the synchronizer chain and keep the last stage's previous value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            prev_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[STAGES-2:0], async_in};
            prev_q <= sync_q[STAGES-1];
        end
    end

    // A rising edge is a new high level on the last stage.
    assign rise_pulse = sync_q[STAGES-1] & ~prev_q;

    AST_EDGE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);  // R5
endmodule

// File: rtl/ptmr_core.sv
// Module: the counter datapath. It loads directly, counts up, reloads from the
// preload at the top value and pulses the overflow request.
// Assumes load_now and step are never both high (load only happens while stopped).
module ptmr_core #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             load_now,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] preload,
    output logic [CNT_W-1:0] count,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] TOP = '1;

    logic past_valid;

    // Count register: direct load, reload at the top value, or increment.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            ovf <= 1'b0;
            if (load_now) begin
                count <= load_val;
            end else if (step) begin
                if (count == TOP) begin
                    count <= preload;
                    ovf   <= 1'b1;
                end else begin
                    count <= count + 1'b1;
                end
            end
        end
    end

    // Marks the cycles in which $past refers to post-reset state.
    always_ff @(posedge clk) begin
        if (!rst_n) past_valid <= 1'b0;
        else        past_valid <= 1'b1;
    end

    AST_OVF_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && ovf) |-> ($past(count) == TOP));  // R7
    AST_STEP_PLUS_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(step) && !$past(load_now) && $past(count) != TOP)
            |-> (count == $past(count) + 1'b1));  // R4
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && !$past(step) && !$past(load_now)) |-> $stable(count));  // R6
    AST_LOAD_STEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && load_now));  // R9
endmodule

// File: rtl/ptmr_top.sv
// Module: register front end of the preloadable timer/event counter. It holds the
// byte-split preload buffer, the control register and the coherent read capture.
// Assumes one register access per cycle. rdata is combinational and valid while rd_en is high.
module ptmr_top #(
    parameter int BYTE_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [BYTE_W-1:0] wdata,
    output logic [BYTE_W-1:0] rdata,
    input  logic              tick_en,
    input  logic              evt_in,
    output logic              ovf_req
);
    import ptmr_pkg::*;

    localparam int CNT_W = 2 * BYTE_W;

    logic [BYTE_W-1:0] lo_buf_q;
    logic [CNT_W-1:0]  preload_q;
    logic [BYTE_W-1:0] hi_cap_q;
    ptmr_mode_e        mode_q;
    logic              run_q;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  new_preload;
    logic              evt_rise;
    logic              step;
    logic              wr_lo, wr_hi, wr_ctrl, rd_lo;
    logic              past_valid;

    assign wr_lo   = wr_en && (addr == ADDR_LO);
    assign wr_hi   = wr_en && (addr == ADDR_HI);
    assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
    assign rd_lo   = rd_en && (addr == ADDR_LO);
    assign new_preload = {wdata, lo_buf_q};

    ptmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_in  (evt_in),
        .rise_pulse(evt_rise)
    );

    // Pick the count source for the selected mode; other modes never step.
    always_comb begin
        step = 1'b0;
        if (run_q) begin
            case (mode_q)
                MODE_TIMER: step = tick_en;
                MODE_EVENT: step = evt_rise;
                default:    step = 1'b0;
            endcase
        end
    end

    ptmr_core #(.CNT_W(CNT_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .load_now(wr_hi && !run_q),
        .load_val(new_preload),
        .preload (preload_q),
        .count   (count),
        .ovf     (ovf_req)
    );

    // Register writes: low-byte buffer, atomic preload commit, control fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_buf_q  <= '0;
            preload_q <= '0;
            mode_q    <= MODE_OFF;
            run_q     <= 1'b0;
        end else begin
            if (wr_lo) lo_buf_q <= wdata;
            if (wr_hi) preload_q <= new_preload;
            if (wr_ctrl) begin
                mode_q <= ptmr_mode_e'(wdata[7:6]);
                run_q  <= wdata[CTRL_RUN_BIT];
            end
        end
    end

    // Capture the count's high byte whenever the low byte is read.
    always_ff @(posedge clk) begin
        if (!rst_n)     hi_cap_q <= '0;
        else if (rd_lo) hi_cap_q <= count[CNT_W-1:BYTE_W];
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                ADDR_LO:   rdata = count[BYTE_W-1:0];
                ADDR_HI:   rdata = hi_cap_q;
                ADDR_CTRL: begin
                    rdata[7:6]          = mode_q;
                    rdata[CTRL_RUN_BIT] = run_q;
                end
                default:   rdata = '0;
            endcase
        end
    end

    // Marks the cycles in which $past refers to post-reset state.
    always_ff @(posedge clk) begin
        if (!rst_n) past_valid <= 1'b0;
        else        past_valid <= 1'b1;
    end

    AST_PRELOAD_ATOMIC: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(wr_hi))
            |-> (preload_q == {$past(wdata), $past(lo_buf_q)}));  // R3
    AST_LO_KEEPS_PRELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && !$past(wr_hi)) |-> $stable(preload_q));  // R2
    AST_RUN_WRITE_NO_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(wr_hi) && $past(run_q) && !$past(step)) |-> $stable(count));  // R9
    AST_OVF_NOT_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && ovf_req) |-> $past(run_q));  // R6
endmodule

// File: tb/ptmr_top_bench.sv
// Bench: a table of preload/tick vectors walked by one loop, then directed tests.
module ptmr_top_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       tick_en = 1'b0;
    logic       evt_in = 1'b0;
    logic       ovf_req;

    int checks = 0;
    int errors = 0;
    int ovf_seen = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ptmr_top u_ptmr_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick_en(tick_en), .evt_in(evt_in),
        .ovf_req(ovf_req)
    );

    // Count overflow pulses away from the active edge.
    always @(negedge clk) if (rst_n && ovf_req) ovf_seen++;

    // Vector: {preload[15:0], ticks[7:0], expected count[15:0], expected overflows[7:0]}
    localparam logic [47:0] VEC [5] = '{
        {16'h1234, 8'd5, 16'h1239, 8'd0},
        {16'hAA9B, 8'd3, 16'hAA9E, 8'd0},
        {16'hFFFD, 8'd5, 16'hFFFF, 8'd1},
        {16'hFFFF, 8'd4, 16'hFFFF, 8'd4},
        {16'hFFFE, 8'd2, 16'hFFFE, 8'd1}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd16(output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(2'd0, lo);
        rd(2'd1, hi);
        v = {hi, lo};
    endtask

    initial begin
        logic [7:0]  b;
        logic [15:0] v, base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1 ovf", ovf_req, 0);
        rd16(v);   check("R1 count", v, 0);
        rd(2'd2, b); check("R1 ctrl", b, 0);

        // R10: control readback and unused address
        wr(2'd2, 8'hFF);
        rd(2'd2, b); check("R10 ctrl", b, 8'hD0);
        rd(2'd3, b); check("R10 addr3", b, 0);
        wr(2'd2, 8'h80);

        // R2: a low-byte write alone changes nothing visible
        wr(2'd0, 8'h55);
        rd16(v);   check("R2 count", v, 0);

        // R3/R4/R7: vector table
        for (int i = 0; i < 5; i++) begin
            wr(2'd2, 8'h80);
            wr(2'd0, VEC[i][39:32]);
            wr(2'd1, VEC[i][47:40]);
            rd16(v); check("R3 preload copy", v, VEC[i][47:32]);
            ovf_seen = 0;
            wr(2'd2, 8'h90);
            if (VEC[i][31:24] != 0) begin
                @(negedge clk); tick_en = 1'b1;
                repeat (VEC[i][31:24]) @(negedge clk);
                tick_en = 1'b0;
            end
            wr(2'd2, 8'h80);
            rd16(v); check("R4/R7 count", v, VEC[i][23:8]);
            check("R7 ovf pulses", ovf_seen, VEC[i][7:0]);
        end

        // R9: preload write while running keeps the count
        wr(2'd0, 8'h00); wr(2'd1, 8'h40);
        wr(2'd2, 8'h90);
        wr(2'd0, 8'h77); wr(2'd1, 8'h66);
        rd16(v); check("R9 count kept", v, 16'h4000);

        // R6: run clear, mode 00 and mode 11 never count
        wr(2'd2, 8'h80); tick_en = 1'b1; repeat (4) @(negedge clk);
        rd16(v); check("R6 run clear", v, 16'h4000);
        wr(2'd2, 8'h10); repeat (4) @(negedge clk);
        rd16(v); check("R6 mode 00", v, 16'h4000);
        wr(2'd2, 8'hD0); evt_in = 1'b1; repeat (6) @(negedge clk);
        evt_in = 1'b0; repeat (4) @(negedge clk);
        rd16(v); check("R6 mode 11", v, 16'h4000);
        tick_en = 1'b0;

        // R5: event mode, one count per rising edge, long high counts once
        wr(2'd2, 8'h50);
        rd16(base);
        evt_in = 1'b1; repeat (3) @(negedge clk); evt_in = 1'b0;
        repeat (5) @(negedge clk);
        rd16(v); check("R5 one edge", v, base + 1);
        evt_in = 1'b1; repeat (12) @(negedge clk);
        rd16(v); check("R5 held high", v, base + 2);
        evt_in = 1'b0; repeat (4) @(negedge clk);
        tick_en = 1'b1; repeat (3) @(negedge clk); tick_en = 1'b0;
        rd16(v); check("R5 tick ignored", v, base + 2);

        // R8: captured high byte survives a later count change
        wr(2'd2, 8'h80);
        wr(2'd0, 8'hFF); wr(2'd1, 8'h12);
        rd(2'd0, b); check("R8 live low", b, 8'hFF);
        wr(2'd0, 8'h00); wr(2'd1, 8'h34);
        rd(2'd1, b); check("R8 captured high", b, 8'h12);
        rd16(v); check("R8 new value", v, 16'h3400);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=timeout expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule